// File: doc/BRIEF.md
# Host-to-Coprocessor Memory Bridge

This block sits between a 16-bit host bus and the work RAM shared with a DSP coprocessor. It decodes each host access into one of four targets. A linear window gives byte and word access to the whole RAM. Two read-only tile windows return RAM words whose word index is a fixed rotation of the host address bits, so the host can fetch tiles in row order. A small mailbox block holds a 16-bit transfer word and a two-bit handshake register. Any address that none of these windows decodes raises a pass-through select for an external I/O decoder.

The host presents one access per cycle as a request strobe with address, direction, size and write data. RAM accesses go out combinationally to a synchronous RAM port. Read data comes back on the host side one cycle later, with a valid strobe. The coprocessor has its own port to load the transfer word and to raise handshake flag 0. It receives three one-cycle wake pulses: two for nonzero word writes to two watched RAM words, and one when the host fills the mailbox.

Top module: `dsp_host_bridge`

## Requirements
- R1: A host access to bytes 0x300000–0x31FFFF drives the RAM in the same cycle at word index addr[16:1]. A word write enables both byte lanes. A byte write enables the upper lane (ram_be=2'b10) at an even address and the lower lane (2'b01) at an odd address, with the byte copied to both lanes of ram_wdata. Read data is valid one cycle later. A byte read returns the upper RAM byte for an even address and the lower byte for an odd address, in host_rdata[7:0] with the upper bits zero.
- R2: A word write with nonzero data to 0x30FE06 pulses wake_a for one cycle, in the cycle after the write. The same write to 0x30FE08 pulses wake_b. The data is written to RAM in both cases. Zero data, byte writes and the same offsets in the upper 64 KiB (0x31xxxx) produce no pulse.
- R3: A word read in 0x390000–0x39FFFF, with w = addr[15:1], reads the RAM word {0, w[14:12], w[5:1], w[11:6], w[0]}.
- R4: A word read in 0x3A0000–0x3AFFFF, with w = addr[15:1], reads the RAM word {0, w[14:11], w[4:1], w[10:5], w[0]}.
- R5: The tile windows serve only word reads. Writes and byte accesses there cause no RAM access, no read response and no pass-through.
- R6: In the register block 0xA15000–0xA1500F, a word read at offset 0x0 or 0x2 returns the transfer word. A read at offset 0x4 returns the handshake register (bit 0 = coprocessor flag, bit 1 = host-wrote flag, other bits zero). Offsets 0x6–0xE read as zero. The response follows one cycle after the request.
- R7: A read of the handshake register returns the old value and clears bit 0 afterwards, so the next read sees bit 0 low.
- R8: A word write to register offset 0x0 or 0x2 loads the transfer word, sets handshake bit 1 and pulses mbox_wake for one cycle in the following cycle. Bit 1 then stays set until reset.
- R9: A byte read in the register block returns the upper byte of the addressed register at an even address and the lower byte at an odd address. A byte read at offset 0x4 or 0x5 clears handshake bit 0 in the same way as a word read.
- R10: Word writes to register offsets 0x4–0xE and every byte write to the register block change no register and raise no pulse.
- R11: cop_xfer_we loads the transfer word from cop_xfer_wdata. If the host writes the transfer word in the same cycle, the host value is kept. cop_flag_set sets handshake bit 0, and it wins over a host read that clears the bit in the same cycle.
- R12: A request outside all windows raises passthru_sel in the same cycle. It causes no RAM access and no read response.
- R13: After reset the transfer word and both flags are zero and no pulse or read response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| host_rvalid | output | 1 | Read response valid, one cycle after the read |
| host_rdata | output | 16 | Read response data |
| passthru_sel | output | 1 | Access belongs to the external I/O decoder |
| ram_en | output | 1 | RAM access this cycle |
| ram_we | output | 1 | RAM write |
| ram_be | output | 2 | RAM byte enables, bit 1 = upper byte |
| ram_addr | output | 16 | RAM word index |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after ram_en |
| wake_a | output | 1 | Pulse: watched word A written nonzero |
| wake_b | output | 1 | Pulse: watched word B written nonzero |
| mbox_wake | output | 1 | Pulse: host loaded the transfer word |
| cop_xfer_we | input | 1 | Coprocessor loads the transfer word |
| cop_xfer_wdata | input | 16 | Coprocessor transfer data |
| cop_flag_set | input | 1 | Coprocessor sets handshake bit 0 |
| cop_xfer | output | 16 | Current transfer word |
| cop_flags | output | 2 | Current handshake flags |

## Verification
RAM address, enables, write data and pass-through are combinational. They are checked in the request cycle, shortly after the inputs change at the falling edge. Read data, the read-valid strobe and the three wake pulses are due one rising edge later. The transfer word and flags take their new values at that same edge. The bench samples all of these at the next falling edge, before the next request is driven. Its mailbox model is updated in request order, so the clear that follows a handshake read, and a coprocessor set in the same cycle, are expected exactly one access later.

// File: rtl/dhb_pkg.sv
package dhb_pkg;

    localparam int DHB_DW = 16;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_LIN,
        WIN_TILE1,
        WIN_TILE2,
        WIN_REGS
    } win_e;

    // pending host read response
    typedef struct packed {
        logic              valid;
        logic              from_ram;
        logic              byte_rd;
        logic              hi;
        logic [DHB_DW-1:0] snap;
    } rsp_t;

    typedef struct packed {
        rsp_t rsp;
        logic wake_a;
        logic wake_b;
    } front_t;

    typedef struct packed {
        logic [DHB_DW-1:0] xfer;
        logic [1:0]        hs;
        logic              wake;
    } mbox_t;

endpackage

// File: rtl/dhb_decode.sv
module dhb_decode
    import dhb_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                LIN_SPAN  = 17,
    parameter int                TILE_SPAN = 16,
    parameter int                REG_SPAN  = 4,
    parameter logic [ADDR_W-1:0] LIN_BASE  = 24'h300000,
    parameter logic [ADDR_W-1:0] T1_BASE   = 24'h390000,
    parameter logic [ADDR_W-1:0] T2_BASE   = 24'h3A0000,
    parameter logic [ADDR_W-1:0] REG_BASE  = 24'hA15000
) (
    input  logic [ADDR_W-1:REG_SPAN] addr_hi,
    output win_e                     win
);

    always_comb begin
        if (addr_hi[ADDR_W-1:LIN_SPAN] == LIN_BASE[ADDR_W-1:LIN_SPAN])
            win = WIN_LIN;
        else if (addr_hi[ADDR_W-1:TILE_SPAN] == T1_BASE[ADDR_W-1:TILE_SPAN])
            win = WIN_TILE1;
        else if (addr_hi[ADDR_W-1:TILE_SPAN] == T2_BASE[ADDR_W-1:TILE_SPAN])
            win = WIN_TILE2;
        else if (addr_hi == REG_BASE[ADDR_W-1:REG_SPAN])
            win = WIN_REGS;
        else
            win = WIN_NONE;
    end

endmodule

// File: rtl/dhb_tile_swizzle.sv
// Rotates word-index bits [LO_W+HI_W:1] down by LO_W; others pass straight.
module dhb_tile_swizzle #(
    parameter int IDX_W = 15,
    parameter int LO_W  = 5,
    parameter int HI_W  = 6
) (
    input  logic [IDX_W-1:0] w,
    output logic [IDX_W-1:0] idx
);

    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        if (i >= 1 && i <= HI_W) begin : g_low
            assign idx[i] = w[i+LO_W];
        end else if (i > HI_W && i <= HI_W + LO_W) begin : g_up
            assign idx[i] = w[i-HI_W];
        end else begin : g_keep
            assign idx[i] = w[i];
        end
    end

endmodule

// File: rtl/dhb_mailbox.sv
module dhb_mailbox
    import dhb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_xfer,
    input  logic [DHB_DW-1:0] host_wdata,
    input  logic              host_rd_hs,
    input  logic              cop_xfer_we,
    input  logic [DHB_DW-1:0] cop_xfer_wdata,
    input  logic              cop_flag_set,
    output logic [DHB_DW-1:0] xfer,
    output logic [1:0]        hs,
    output logic              wake
);

    mbox_t mb_d, mb_q;

    always_comb begin
        mb_d      = mb_q;
        mb_d.wake = 1'b0;
        if (host_wr_xfer) begin
            mb_d.xfer  = host_wdata;
            mb_d.hs[1] = 1'b1;
            mb_d.wake  = 1'b1;
        end else if (cop_xfer_we) begin
            mb_d.xfer = cop_xfer_wdata;
        end
        if (cop_flag_set)
            mb_d.hs[0] = 1'b1;
        else if (host_rd_hs)
            mb_d.hs[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mb_q <= '0;
        else        mb_q <= mb_d;
    end

    assign xfer = mb_q.xfer;
    assign hs   = mb_q.hs;
    assign wake = mb_q.wake;

endmodule

// File: rtl/dsp_host_bridge.sv
module dsp_host_bridge
    import dhb_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter int                RAM_AW     = 16,
    parameter int                TILE1_LO_W = 5,
    parameter int                TILE2_LO_W = 4,
    parameter int                TILE_HI_W  = 6,
    parameter logic [ADDR_W-1:0] LIN_BASE   = 24'h300000,
    parameter logic [ADDR_W-1:0] T1_BASE    = 24'h390000,
    parameter logic [ADDR_W-1:0] T2_BASE    = 24'h3A0000,
    parameter logic [ADDR_W-1:0] REG_BASE   = 24'hA15000,
    parameter logic [RAM_AW:0]   WATCH_A    = 17'h0FE06,
    parameter logic [RAM_AW:0]   WATCH_B    = 17'h0FE08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_word,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic              host_rvalid,
    output logic [15:0]       host_rdata,
    output logic              passthru_sel,
    output logic              ram_en,
    output logic              ram_we,
    output logic [1:0]        ram_be,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata,
    output logic              wake_a,
    output logic              wake_b,
    output logic              mbox_wake,
    input  logic              cop_xfer_we,
    input  logic [15:0]       cop_xfer_wdata,
    input  logic              cop_flag_set,
    output logic [15:0]       cop_xfer,
    output logic [1:0]        cop_flags
);

    localparam int LIN_SPAN  = RAM_AW + 1;
    localparam int TILE_SPAN = RAM_AW;
    localparam int REG_SPAN  = 4;
    localparam int IDX_W     = RAM_AW - 1;

    win_e             win;
    logic [IDX_W-1:0] w, idx1, idx2;
    logic [2:0]       reg_sel;
    logic             wr_xfer, rd_hs, rd_go;
    logic [15:0]      src;
    front_t           f_d, f_q;

    assign w       = host_addr[IDX_W:1];
    assign reg_sel = host_addr[3:1];

    dhb_decode #(
        .ADDR_W(ADDR_W), .LIN_SPAN(LIN_SPAN), .TILE_SPAN(TILE_SPAN),
        .REG_SPAN(REG_SPAN), .LIN_BASE(LIN_BASE), .T1_BASE(T1_BASE),
        .T2_BASE(T2_BASE), .REG_BASE(REG_BASE)
    ) u_dec (
        .addr_hi (host_addr[ADDR_W-1:REG_SPAN]),
        .win     (win)
    );

    dhb_tile_swizzle #(.IDX_W(IDX_W), .LO_W(TILE1_LO_W), .HI_W(TILE_HI_W))
        u_swz1 (.w(w), .idx(idx1));

    dhb_tile_swizzle #(.IDX_W(IDX_W), .LO_W(TILE2_LO_W), .HI_W(TILE_HI_W))
        u_swz2 (.w(w), .idx(idx2));

    // host-side mailbox strobes
    always_comb begin
        wr_xfer = host_req && (win == WIN_REGS) && host_we && host_word
                  && (reg_sel <= 3'd1);
        rd_hs   = host_req && (win == WIN_REGS) && !host_we && (reg_sel == 3'd2);
    end

    dhb_mailbox u_mbox (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr_xfer   (wr_xfer),
        .host_wdata     (host_wdata),
        .host_rd_hs     (rd_hs),
        .cop_xfer_we    (cop_xfer_we),
        .cop_xfer_wdata (cop_xfer_wdata),
        .cop_flag_set   (cop_flag_set),
        .xfer           (cop_xfer),
        .hs             (cop_flags),
        .wake           (mbox_wake)
    );

    always_comb begin
        f_d          = '0;
        passthru_sel = 1'b0;
        ram_en       = 1'b0;
        ram_we       = 1'b0;
        ram_be       = 2'b00;
        ram_addr     = '0;
        ram_wdata    = '0;
        rd_go        = host_req && !host_we;

        unique case (win)
            WIN_LIN: begin
                ram_en    = host_req;
                ram_we    = host_req && host_we;
                ram_addr  = host_addr[RAM_AW:1];
                ram_be    = host_word ? 2'b11 : (host_addr[0] ? 2'b01 : 2'b10);
                ram_wdata = host_word ? host_wdata : {2{host_wdata[7:0]}};
                f_d.rsp.valid    = rd_go;
                f_d.rsp.from_ram = 1'b1;
                f_d.wake_a = host_req && host_we && host_word && (host_wdata != '0)
                             && (host_addr[RAM_AW:0] == WATCH_A);
                f_d.wake_b = host_req && host_we && host_word && (host_wdata != '0)
                             && (host_addr[RAM_AW:0] == WATCH_B);
            end
            WIN_TILE1, WIN_TILE2: begin
                ram_en   = rd_go && host_word;
                ram_addr = {1'b0, (win == WIN_TILE1) ? idx1 : idx2};
                f_d.rsp.valid    = rd_go && host_word;
                f_d.rsp.from_ram = 1'b1;
            end
            WIN_REGS: begin
                f_d.rsp.valid = rd_go;
                case (reg_sel)
                    3'd0, 3'd1: f_d.rsp.snap = cop_xfer;
                    3'd2:       f_d.rsp.snap = {14'd0, cop_flags};
                    default:    f_d.rsp.snap = '0;
                endcase
            end
            default: passthru_sel = host_req;
        endcase

        f_d.rsp.byte_rd = !host_word;
        f_d.rsp.hi      = !host_addr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        src         = f_q.rsp.from_ram ? ram_rdata : f_q.rsp.snap;
        host_rvalid = f_q.rsp.valid;
        if (!f_q.rsp.valid)
            host_rdata = '0;
        else if (!f_q.rsp.byte_rd)
            host_rdata = src;
        else
            host_rdata = {8'd0, f_q.rsp.hi ? src[15:8] : src[7:0]};
    end

    assign wake_a = f_q.wake_a;
    assign wake_b = f_q.wake_b;

endmodule

// File: rtl/dhb_checker.sv
module dhb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_we,
    input logic        host_word,
    input logic [23:0] host_addr,
    input logic [15:0] host_wdata,
    input logic        host_rvalid,
    input logic        passthru_sel,
    input logic        ram_en,
    input logic        wake_a,
    input logic        wake_b,
    input logic        mbox_wake,
    input logic        cop_flag_set,
    input logic [1:0]  cop_flags
);

    assert_rvalid_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_req && !host_we));

    assert_wake_a_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_a |-> $past(host_req && host_we && host_word
                         && host_addr == 24'h30FE06 && host_wdata != 16'd0));

    assert_wake_b_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_b |-> $past(host_req && host_we && host_word
                         && host_addr == 24'h30FE08 && host_wdata != 16'd0));

    assert_tile_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && (host_addr[23:16] == 8'h39 || host_addr[23:16] == 8'h3A))
        |-> !ram_en);

    assert_mbox_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_wake |-> $past(host_req && host_we && host_word
                            && host_addr[23:4] == 20'hA1500 && host_addr[3:2] == 2'b00));

    assert_flag1_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cop_flags[1]));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cop_flag_set |=> cop_flags[0]);

    assert_passthru_no_ram_R12: assert property (@(posedge clk) disable iff (!rst_n)
        passthru_sel |-> !ram_en);

endmodule

bind dsp_host_bridge dhb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_word    (host_word),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_rvalid  (host_rvalid),
    .passthru_sel (passthru_sel),
    .ram_en       (ram_en),
    .wake_a       (wake_a),
    .wake_b       (wake_b),
    .mbox_wake    (mbox_wake),
    .cop_flag_set (cop_flag_set),
    .cop_flags    (cop_flags)
);

// File: tb/dsp_host_bridge_bench.sv
`timescale 1ns/1ps
module dsp_host_bridge_bench;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_word = 1'b0;
    logic [23:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_rvalid;
    logic [15:0] host_rdata;
    logic        passthru_sel, ram_en, ram_we;
    logic [1:0]  ram_be;
    logic [15:0] ram_addr, ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        wake_a, wake_b, mbox_wake;
    logic        cop_xfer_we = 1'b0, cop_flag_set = 1'b0;
    logic [15:0] cop_xfer_wdata = '0;
    logic [15:0] cop_xfer;
    logic [1:0]  cop_flags;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_xfer = '0;
    logic [1:0]  m_hs = '0;

    always #(CLK_NS/2) clk = ~clk;

    dsp_host_bridge u_dsp_host_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .passthru_sel(passthru_sel), .ram_en(ram_en), .ram_we(ram_we),
        .ram_be(ram_be), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .wake_a(wake_a), .wake_b(wake_b),
        .mbox_wake(mbox_wake), .cop_xfer_we(cop_xfer_we),
        .cop_xfer_wdata(cop_xfer_wdata), .cop_flag_set(cop_flag_set),
        .cop_xfer(cop_xfer), .cop_flags(cop_flags)
    );

    // RAM stand-in: the content of each word is a fixed function of its index
    function automatic logic [15:0] ramval(input logic [15:0] idx);
        return idx ^ 16'h5A3C;
    endfunction

    always @(posedge clk)
        if (ram_en && !ram_we) ram_rdata <= ramval(ram_addr);

    function automatic logic [14:0] perm1(input logic [14:0] w);
        return {w[14:12], w[5:1], w[11:6], w[0]};
    endfunction

    function automatic logic [14:0] perm2(input logic [14:0] w);
        return {w[14:11], w[4:1], w[10:5], w[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One host access, optionally with coprocessor activity in the same cycle.
    // Called at a falling edge; returns at the next falling edge.
    task automatic host_op(input logic we, input logic word, input logic [23:0] a,
                           input logic [15:0] d, input logic cs, input logic cw,
                           input logic [15:0] cwd);
        logic lin, t1, t2, rg, pass, e_en, e_rv, ewa, ewb, hw, clr;
        logic [15:0] e_ra, src, e_rd;
        lin  = (a[23:17] == 7'h18);
        t1   = (a[23:16] == 8'h39);
        t2   = (a[23:16] == 8'h3A);
        rg   = (a[23:4] == 20'hA1500);
        pass = !(lin || t1 || t2 || rg);
        host_req = 1'b1; host_we = we; host_word = word; host_addr = a;
        host_wdata = d; cop_flag_set = cs; cop_xfer_we = cw; cop_xfer_wdata = cwd;
        e_en = lin || ((t1 || t2) && !we && word);
        e_ra = lin ? a[16:1] : (t1 ? {1'b0, perm1(a[15:1])} : {1'b0, perm2(a[15:1])});
        #1;
        chk("R12 passthru", {31'd0, passthru_sel}, {31'd0, pass});
        if (t1 || t2) chk("R5 tile ram_en", {31'd0, ram_en}, {31'd0, e_en});
        else          chk("R1 ram_en", {31'd0, ram_en}, {31'd0, e_en});
        if (e_en) begin
            if (t1)      chk("R3 tile1 index", {16'd0, ram_addr}, {16'd0, e_ra});
            else if (t2) chk("R4 tile2 index", {16'd0, ram_addr}, {16'd0, e_ra});
            else         chk("R1 lin index", {16'd0, ram_addr}, {16'd0, e_ra});
        end
        if (lin && we) begin
            chk("R1 ram_we", {31'd0, ram_we}, 32'd1);
            chk("R1 ram_be", {30'd0, ram_be},
                {30'd0, word ? 2'b11 : (a[0] ? 2'b01 : 2'b10)});
            chk("R1 ram_wdata", {16'd0, ram_wdata},
                {16'd0, word ? d : {d[7:0], d[7:0]}});
        end
        if (rg) begin
            case (a[3:1])
                3'd0, 3'd1: src = m_xfer;
                3'd2:       src = {14'd0, m_hs};
                default:    src = 16'd0;
            endcase
        end else begin
            src = ramval(e_ra);
        end
        e_rv = !we && (lin || rg || ((t1 || t2) && word));
        e_rd = word ? src : (a[0] ? {8'd0, src[7:0]} : {8'd0, src[15:8]});
        ewa  = we && word && (a == 24'h30FE06) && (d != 16'd0);
        ewb  = we && word && (a == 24'h30FE08) && (d != 16'd0);
        hw   = rg && we && word && (a[3:1] <= 3'd1);
        clr  = rg && !we && (a[3:1] == 3'd2);
        if (hw)      m_xfer = d;
        else if (cw) m_xfer = cwd;
        if (hw) m_hs[1] = 1'b1;
        if (cs)       m_hs[0] = 1'b1;
        else if (clr) m_hs[0] = 1'b0;
        @(negedge clk);
        chk("R1 R5 R6 R12 rvalid", {31'd0, host_rvalid}, {31'd0, e_rv});
        if (e_rv) begin
            if (t1)      chk("R3 tile1 data", {16'd0, host_rdata}, {16'd0, e_rd});
            else if (t2) chk("R4 tile2 data", {16'd0, host_rdata}, {16'd0, e_rd});
            else if (rg) chk("R6 R7 R9 reg data", {16'd0, host_rdata}, {16'd0, e_rd});
            else         chk("R1 lin data", {16'd0, host_rdata}, {16'd0, e_rd});
        end
        chk("R2 wake_a", {31'd0, wake_a}, {31'd0, ewa});
        chk("R2 wake_b", {31'd0, wake_b}, {31'd0, ewb});
        chk("R8 R10 mbox_wake", {31'd0, mbox_wake}, {31'd0, hw});
        chk("R8 R10 R11 xfer", {16'd0, cop_xfer}, {16'd0, m_xfer});
        chk("R7 R8 R11 flags", {30'd0, cop_flags}, {30'd0, m_hs});
        host_req = 1'b0; cop_flag_set = 1'b0; cop_xfer_we = 1'b0;
    endtask

    task automatic rd(input logic word, input logic [23:0] a);
        host_op(1'b0, word, a, 16'd0, 1'b0, 1'b0, 16'd0);
    endtask

    task automatic wr(input logic word, input logic [23:0] a, input logic [15:0] d);
        host_op(1'b1, word, a, d, 1'b0, 1'b0, 16'd0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h1D2C3B4A);
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 xfer", {16'd0, cop_xfer}, 32'd0);
        chk("R13 flags", {30'd0, cop_flags}, 32'd0);
        chk("R13 rvalid", {31'd0, host_rvalid}, 32'd0);
        chk("R13 wakes", {29'd0, wake_a, wake_b, mbox_wake}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 linear window
        rd(1'b1, 24'h300000); rd(1'b1, 24'h31FFFE); rd(1'b0, 24'h301235); rd(1'b0, 24'h301234);
        wr(1'b1, 24'h302468, 16'hBEEF); wr(1'b0, 24'h302469, 16'h0077); wr(1'b0, 24'h30246A, 16'h0088);
        // R2 watched words
        wr(1'b1, 24'h30FE06, 16'h0001); wr(1'b1, 24'h30FE06, 16'h0000);
        wr(1'b1, 24'h30FE08, 16'h8000); wr(1'b1, 24'h31FE06, 16'h1234);
        wr(1'b0, 24'h30FE06, 16'h00FF); wr(1'b1, 24'h30FE04, 16'h5555);
        // R3 / R4 permutations at edge patterns
        rd(1'b1, 24'h390000); rd(1'b1, 24'h39FFFE); rd(1'b1, 24'h390040); rd(1'b1, 24'h391F82);
        rd(1'b1, 24'h3A0000); rd(1'b1, 24'h3AFFFE); rd(1'b1, 24'h3A0020); rd(1'b1, 24'h3A0FC2);
        // R5 tile windows refuse writes and byte reads
        wr(1'b1, 24'h390010, 16'h1111); rd(1'b0, 24'h3A0011); wr(1'b0, 24'h3A0010, 16'h22);
        // R6 R8 mailbox
        rd(1'b1, 24'hA15000); rd(1'b1, 24'hA15004);
        wr(1'b1, 24'hA15000, 16'hC0DE); rd(1'b1, 24'hA15002); rd(1'b1, 24'hA15004);
        wr(1'b1, 24'hA15002, 16'h1357);
        for (int o = 6; o < 16; o += 2) rd(1'b1, 24'hA15000 + 24'(o));
        // R7 clear after read, R11 set wins
        host_op(1'b0, 1'b1, 24'h000100, 16'd0, 1'b1, 1'b0, 16'd0);
        rd(1'b1, 24'hA15004); rd(1'b1, 24'hA15004);
        host_op(1'b0, 1'b1, 24'hA15004, 16'd0, 1'b1, 1'b0, 16'd0);
        rd(1'b1, 24'hA15004);
        // R9 byte reads
        rd(1'b0, 24'hA15000); rd(1'b0, 24'hA15001); rd(1'b0, 24'hA15003);
        host_op(1'b0, 1'b1, 24'h000100, 16'd0, 1'b1, 1'b0, 16'd0);
        rd(1'b0, 24'hA15005); rd(1'b0, 24'hA15004);
        // R10 ignored writes
        wr(1'b1, 24'hA15004, 16'hFFFF); wr(1'b1, 24'hA1500E, 16'hAAAA);
        wr(1'b0, 24'hA15000, 16'h00EE); wr(1'b0, 24'hA15003, 16'h00DD);
        rd(1'b1, 24'hA15000); rd(1'b1, 24'hA15004);
        // R11 coprocessor transfer write, host wins on collision
        host_op(1'b0, 1'b1, 24'h000200, 16'd0, 1'b0, 1'b1, 16'h4242);
        host_op(1'b1, 1'b1, 24'hA15000, 16'h9999, 1'b0, 1'b1, 16'h6666);
        // R12 pass-through
        rd(1'b1, 24'hA10000); wr(1'b1, 24'hA15010, 16'h1); rd(1'b0, 24'h000001);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] x, k;
            logic [23:0] a;
            logic word, we, cs, cw;
            x = $urandom; k = $urandom;
            word = x[4]; we = x[5];
            cs = (x[7:6] == 2'b00); cw = (x[10:8] == 3'b000);
            case (x[2:0] % 3'd6)
                3'd0: a = 24'h300000 + {7'd0, k[16:0]};
                3'd1: a = 24'h30FE00 + {16'd0, k[3:0], 4'd0} % 24'h10 + 24'(k[5:4] == 2'b00 ? 6 : 8);
                3'd2: begin a = 24'h390000 + {8'd0, k[15:0]}; word = 1'b1; we = x[12] & x[13]; end
                3'd3: begin a = 24'h3A0000 + {8'd0, k[15:0]}; word = 1'b1; we = x[12] & x[13]; end
                3'd4: a = 24'hA15000 + {20'd0, k[3:0]};
                default: a = {12'hA10, k[11:0]};
            endcase
            if (word) a[0] = 1'b0;
            host_op(we, word, a, (x[11] ? 16'd0 : k[31:16]), cs, cw, x[31:16]);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule